// File: doc/BRIEF.md
# Byte-wide arithmetic and logic unit with iterative multiply and divide

This block is the arithmetic core of a small 8-bit processor. A `start` pulse captures an operation code, two operands, a signed-mode bit and a carry input. Most operations finish in a single clock. Multiply and divide run over several clocks behind a `busy` signal. The result byte and three flags (carry, zero, sign) are held in output registers until the next operation finishes, and a one-cycle `done` pulse marks each finish.

The carry input joins bytes together when a wider addition or subtraction is split into byte steps. In unsigned mode the carry flag reports the carry or borrow out. In signed mode it reports two's-complement overflow instead. Signed mode also makes multiply and divide treat their operands as signed values. Register storage and instruction decode are not part of this block.

Top module: `byte_alu`

## Requirements
- R1: While reset is held, and after it is released until the first finish, `result` is 0x00, `carry` is 0, `zero` is 1, `sign` is 0, and both `busy` and `done` are 0.
- R2: Operation codes are as follows. 0 gives the bitwise inverse of `a`, 8 gives `a & b`, 9 gives `a | b`, and codes 10 to 15 return `a` unchanged. All of these clear carry.
- R3: Code 1 gives the negation 0-`a`, code 2 gives `a`+1 and code 3 gives `a`-1, all modulo 256. `carry_in` has no effect on them. In unsigned mode the carry flag is the carry out for code 2, and it is the borrow for codes 1 and 3 (set when `a` is 0x00 for code 3, and when `a` is nonzero for code 1).
- R4: Code 4 gives `a`+`b`+`carry_in` and code 5 gives `a`-`b`-`carry_in`, both modulo 256. In unsigned mode the carry flag is the carry out of the addition, or the borrow of the subtraction (set when the exact difference is negative).
- R5: When `signed_mode` is 1, the carry flag for codes 1 to 5 is set exactly when the exact signed result lies outside -128..127.
- R6: Code 6 returns the low byte of `a`*`b`. Unsigned: carry is set when the product exceeds 255. Signed: the operands are signed and carry is set when the signed product lies outside -128..127.
- R7: Code 7 returns the quotient of `a`/`b`, truncated toward zero (signed operands when `signed_mode` is 1). Carry is 0, except that a zero divisor returns 0xFF with carry set, and the signed quotient 128 (-128/-1) returns 0x80 with carry set.
- R8: `zero` is 1 exactly when `result` is 0x00, and `sign` always equals `result` bit 7.
- R9: A start of codes other than 6 and 7 gives `done` and the new outputs one cycle later, and `busy` is never raised for them. A start of code 6 or 7 raises `busy` for exactly 8 cycles; `busy` then falls in the same cycle that `done` pulses with the new outputs.
- R10: A `start` while `busy` is high is ignored. Outputs change only in a cycle where `done` is 1, and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation with the inputs present this cycle |
| op | input | 4 | Operation code (see R2 to R7) |
| signed_mode | input | 1 | 1 selects signed interpretation |
| carry_in | input | 1 | Carry or borrow in for codes 4 and 5 |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| result | output | 8 | Result byte of the last finished operation |
| carry | output | 1 | Carry, borrow or overflow flag |
| zero | output | 1 | Result is zero |
| sign | output | 1 | Copy of result bit 7 |
| busy | output | 1 | Multiply or divide in progress |
| done | output | 1 | One-cycle pulse when new outputs appear |

## Verification
The cases hardest to reach are the edges of the iterative unit. Examples are the signed quotient of -128 by -1, a zero divisor in either mode, and signed products whose magnitude reaches exactly 128. A second hard case is a `start` that lands while the iterative unit is busy. The stimulus sweeps twenty operand values in every pair, in both modes and with both carry inputs. Six of those values are fixed at 0x00, 0x01, 0x7F, 0x80, 0x81 and 0xFF, so each such edge is hit by construction. A separate sequence pulses `start` with different operands in the middle of a multiply, then checks that the multiply result and its finish cycle are unchanged.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_NOT = 4'd0,
    OP_NEG = 4'd1,
    OP_INC = 4'd2,
    OP_DEC = 4'd3,
    OP_ADD = 4'd4,
    OP_SUB = 4'd5,
    OP_MUL = 4'd6,
    OP_DIV = 4'd7,
    OP_AND = 4'd8,
    OP_OR  = 4'd9
  } alu_op_e;

endpackage

// File: rtl/byte_alu_simple.sv
module byte_alu_simple
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic         sgn,
  input  logic         cin,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         cy
);

  localparam int MSB = W - 1;

  function automatic logic [W:0] add_c(input logic [W-1:0] x, input logic [W-1:0] z,
                                       input logic c);
    return {1'b0, x} + {1'b0, z} + {{W{1'b0}}, c};
  endfunction

  function automatic logic [W:0] sub_b(input logic [W-1:0] x, input logic [W-1:0] z,
                                       input logic c);
    return {1'b0, x} - {1'b0, z} - {{W{1'b0}}, c};
  endfunction

  function automatic logic add_ovf(input logic [W-1:0] x, input logic [W-1:0] z,
                                   input logic [W-1:0] s);
    return (x[MSB] == z[MSB]) && (s[MSB] != x[MSB]);
  endfunction

  function automatic logic sub_ovf(input logic [W-1:0] x, input logic [W-1:0] z,
                                   input logic [W-1:0] s);
    return (x[MSB] != z[MSB]) && (s[MSB] != x[MSB]);
  endfunction

  logic [W-1:0] add_x, add_z, sub_x, sub_z;
  logic         add_ci, sub_ci;
  logic [W:0]   sum_w, dif_w;

  // one adder and one subtractor shared by all arithmetic codes
  always_comb begin
    add_x  = a;
    add_z  = b;
    add_ci = cin;
    sub_x  = a;
    sub_z  = b;
    sub_ci = cin;
    case (op)
      OP_INC: begin
        add_z  = '0;
        add_ci = 1'b1;
      end
      OP_DEC: begin
        sub_z  = '0;
        sub_ci = 1'b1;
      end
      OP_NEG: begin
        sub_x  = '0;
        sub_z  = a;
        sub_ci = 1'b0;
      end
      default: ;
    endcase
  end

  assign sum_w = add_c(add_x, add_z, add_ci);
  assign dif_w = sub_b(sub_x, sub_z, sub_ci);

  always_comb begin
    y  = a;
    cy = 1'b0;
    case (op)
      OP_NOT: y = ~a;
      OP_AND: y = a & b;
      OP_OR:  y = a | b;
      OP_INC, OP_ADD: begin
        y  = sum_w[W-1:0];
        cy = sgn ? add_ovf(add_x, add_z, sum_w[W-1:0]) : sum_w[W];
      end
      OP_NEG, OP_DEC, OP_SUB: begin
        y  = dif_w[W-1:0];
        cy = sgn ? sub_ovf(sub_x, sub_z, dif_w[W-1:0]) : dif_w[W];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/byte_alu_iter.sv
module byte_alu_iter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         is_div,
  input  logic         sgn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         last,
  output logic         div_zero_end,
  output logic [W-1:0] y,
  output logic         cy
);

  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] x, input logic s);
    return (s && x[W-1]) ? -x : x;
  endfunction

  // one iteration: shift-add for multiply, restoring step for divide
  function automatic logic [2*W-1:0] step(input logic [2*W-1:0] st, input logic [W-1:0] m,
                                          input logic dv);
    logic [W:0] part;
    logic [W:0] trial;
    if (!dv) begin
      part = {1'b0, st[2*W-1:W]} + (st[0] ? {1'b0, m} : {(W+1){1'b0}});
      return {part, st[W-1:1]};
    end
    trial = {st[2*W-1:W], st[W-1]} - {1'b0, m};
    if (trial[W]) return {st[2*W-2:W], st[W-1], st[W-2:0], 1'b0};
    return {trial[W-1:0], st[W-2:0], 1'b1};
  endfunction

  logic [2*W-1:0] acc, acc_nx, prod;
  logic [W-1:0]   dvs, quo;
  logic [CW-1:0]  cnt;
  logic           run, dv_q, sg_q, flip_q, dz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      dvs    <= '0;
      cnt    <= '0;
      run    <= 1'b0;
      dv_q   <= 1'b0;
      sg_q   <= 1'b0;
      flip_q <= 1'b0;
      dz_q   <= 1'b0;
    end else if (go) begin
      acc    <= {{W{1'b0}}, magnitude(a, sgn)};
      dvs    <= magnitude(b, sgn);
      cnt    <= '0;
      run    <= 1'b1;
      dv_q   <= is_div;
      sg_q   <= sgn;
      flip_q <= sgn && (a[W-1] ^ b[W-1]);
      dz_q   <= (b == '0);
    end else if (run) begin
      acc <= acc_nx;
      cnt <= cnt + CW'(1);
      if (cnt == LAST_CNT) run <= 1'b0;
    end
  end

  assign acc_nx       = step(acc, dvs, dv_q);
  assign busy         = run;
  assign last         = run && (cnt == LAST_CNT);
  assign div_zero_end = last && dv_q && dz_q;

  assign prod = flip_q ? -acc_nx : acc_nx;
  assign quo  = flip_q ? -acc_nx[W-1:0] : acc_nx[W-1:0];

  always_comb begin
    if (!dv_q) begin
      y  = prod[W-1:0];
      cy = sg_q ? (prod[2*W-1:W] != {W{prod[W-1]}}) : (|prod[2*W-1:W]);
    end else if (dz_q) begin
      y  = '1;
      cy = 1'b1;
    end else begin
      y  = quo;
      cy = sg_q && !flip_q && acc_nx[W-1];
    end
  end

endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [3:0]   op,
  input  logic         signed_mode,
  input  logic         carry_in,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         carry,
  output logic         zero,
  output logic         sign,
  output logic         busy,
  output logic         done
);

  logic         is_iter, accept_start, fin_single, fin_iter, fin_div_zero;
  logic [W-1:0] simple_y, iter_y, next_y;
  logic         simple_cy, iter_cy, next_cy;

  assign is_iter      = (op == OP_MUL) || (op == OP_DIV);
  assign accept_start = start && !busy;
  assign fin_single   = accept_start && !is_iter;

  byte_alu_simple #(.W(W)) u_simple (
    .op  (op),
    .sgn (signed_mode),
    .cin (carry_in),
    .a   (a),
    .b   (b),
    .y   (simple_y),
    .cy  (simple_cy)
  );

  byte_alu_iter #(.W(W)) u_iter (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (accept_start && is_iter),
    .is_div       (op == OP_DIV),
    .sgn          (signed_mode),
    .a            (a),
    .b            (b),
    .busy         (busy),
    .last         (fin_iter),
    .div_zero_end (fin_div_zero),
    .y            (iter_y),
    .cy           (iter_cy)
  );

  assign next_y  = fin_iter ? iter_y : simple_y;
  assign next_cy = fin_iter ? iter_cy : simple_cy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      carry  <= 1'b0;
      zero   <= 1'b1;
      sign   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= fin_single || fin_iter;
      if (fin_single || fin_iter) begin
        result <= next_y;
        carry  <= next_cy;
        zero   <= (next_y == '0);
        sign   <= next_y[W-1];
      end
    end
  end

endmodule

// File: rtl/byte_alu_props.sv
module byte_alu_props #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic         fin_single,
  input logic         fin_div_zero,
  input logic         carry,
  input logic         zero,
  input logic         sign,
  input logic [W-1:0] result
);

  localparam int BW = $clog2(W + 1) + 1;

  logic [BW-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + BW'(1);
    else           busy_run <= '0;
  end

  assert_busy_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == BW'(W)));

  assert_fall_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_busy_not_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  assert_single_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fin_single |=> (done && !busy));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(carry)));

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    zero == (result == '0));

  assert_sign_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sign == result[W-1]);

  assert_div_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fin_div_zero |=> ((result == '1) && carry));

endmodule

bind byte_alu byte_alu_props #(.W(W)) u_props (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .fin_single   (fin_single),
  .fin_div_zero (fin_div_zero),
  .carry        (carry),
  .zero         (zero),
  .sign         (sign),
  .result       (result)
);

// File: tb/byte_alu_test.sv
module byte_alu_test;

  localparam int PERIOD = 10;
  localparam int W      = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   op = '0;
  logic         signed_mode = 1'b0;
  logic         carry_in = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [W-1:0] result;
  logic         carry, zero, sign, busy, done;

  int checks = 0;
  int errors = 0;

  byte_alu #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .signed_mode(signed_mode),
    .carry_in(carry_in), .a(a), .b(b), .result(result), .carry(carry), .zero(zero),
    .sign(sign), .busy(busy), .done(done)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic bit out8(input int v);
    return (v > 127) || (v < -128);
  endfunction

  // arithmetic restatement of R2..R7
  function automatic void model(input int o, input int x, input int z, input bit sm,
                                input bit ci, output int y, output bit cy);
    int r;
    int sa = sx(x);
    int sb = sx(z);
    cy = 1'b0;
    r  = x;
    case (o)
      0: r = 255 - x;
      1: begin r = sm ? -sa : -x;          cy = sm ? out8(r) : (x != 0); end
      2: begin r = sm ? sa + 1 : x + 1;    cy = sm ? out8(r) : (r > 255); end
      3: begin r = sm ? sa - 1 : x - 1;    cy = sm ? out8(r) : (r < 0); end
      4: begin r = sm ? sa + sb + ci : x + z + ci; cy = sm ? out8(r) : (r > 255); end
      5: begin r = sm ? sa - sb - ci : x - z - ci; cy = sm ? out8(r) : (r < 0); end
      6: begin r = sm ? sa * sb : x * z;    cy = sm ? out8(r) : (r > 255); end
      7: begin
        if (z == 0) begin r = 255; cy = 1'b1; end
        else if (sm) begin r = sa / sb; cy = (r > 127); end
        else r = x / z;
      end
      8: r = x & z;
      9: r = x | z;
      default: r = x;
    endcase
    y = r & 255;
  endfunction

  function automatic string req_of(input int o, input bit sm);
    if (o == 6) return "R6";
    if (o == 7) return "R7";
    if (o >= 1 && o <= 5) return sm ? "R5" : ((o >= 4) ? "R4" : "R3");
    return "R2";
  endfunction

  task automatic run_op(input int o, input int x, input int z, input bit sm, input bit ci);
    int ey, lat, elat;
    bit ecy;
    model(o, x, z, sm, ci, ey, ecy);
    @(negedge clk);
    op = 4'(o); a = 8'(x); b = 8'(z); signed_mode = sm; carry_in = ci; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    if (o == 6 || o == 7) chk(busy == 1'b1, "R9 busy", int'(busy), 1);
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    elat = (o == 6 || o == 7) ? W + 1 : 1;
    chk(lat == elat, "R9 latency", lat, elat);
    chk({carry, result} == {ecy, 8'(ey)}, req_of(o, sm), int'({carry, result}),
        int'({ecy, 8'(ey)}));
    chk({zero, sign} == {(ey == 0), ey[7]}, "R8", int'({zero, sign}),
        int'({(ey == 0), ey[7]}));
  endtask

  function automatic int pick(input int k);
    case (k)
      0: return 0;
      1: return 1;
      2: return 127;
      3: return 128;
      4: return 129;
      5: return 255;
      default: return (k * 37 + 11) & 255;
    endcase
  endfunction

  initial begin
    #(PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, held and just after release
    chk({result, carry, zero, sign, busy, done} == {8'h00, 5'b01000}, "R1 held",
        int'({result, carry, zero, sign, busy, done}), 'h8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({result, carry, zero, sign, busy, done} == {8'h00, 5'b01000}, "R1 released",
        int'({result, carry, zero, sign, busy, done}), 'h8);

    // R3 / R5: unary codes over every operand, carry_in varied to show it is ignored
    for (int x = 0; x < 256; x++)
      for (int o = 0; o < 4; o++)
        for (int m = 0; m < 2; m++)
          run_op(o, x, 0, bit'(m), bit'(x[0] ^ m[0]));

    // R2, R4..R9: operand pair sweep over all remaining codes
    for (int i = 0; i < 20; i++)
      for (int j = 0; j < 20; j++)
        for (int o = 4; o < 16; o++)
          for (int m = 0; m < 2; m++)
            for (int c = 0; c < 2; c++)
              run_op(o, pick(i), pick(j), bit'(m), bit'(c));

    // R10: a start during a multiply is ignored
    @(negedge clk);
    op = 4'd6; a = 8'd12; b = 8'd11; signed_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    op = 4'd4; a = 8'd1; b = 8'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int lat = 3;
      while (!done && lat < 40) begin
        @(negedge clk);
        lat++;
      end
      chk(lat == W + 1, "R10 latency", lat, W + 1);
    end
    chk({carry, result} == {1'b0, 8'h84}, "R10 result", int'({carry, result}), 'h84);
    repeat (3) @(negedge clk);
    chk({done, busy, carry, result} == {3'b000, 8'h84}, "R10 hold",
        int'({done, busy, carry, result}), 'h84);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule